// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer, nine bits wide by default, whose write side and read side run on unrelated clocks. A producer pushes words on the write clock through two write qualifiers. A consumer pulls them into a registered output on the read clock through two read qualifiers. Four active-low status flags are produced, each registered in the clock domain that consumes it: empty and almost-empty on the read clock, full and almost-full on the write clock. The two pointers cross between domains in Gray code through two-stage synchronizers. The flags can therefore release late, but they never release early.

The second write qualifier has two roles, and the write side holds a small mode state machine that picks one. While `rst_n` is low, every write-clock edge samples `wr_en2_ld` into the mode register. A high level enters state MODE_TWO_EN, and a low level enters state MODE_LOAD. The only transition is this capture during reset. After reset release, the state holds unchanged in both states (the hold transition). In MODE_LOAD the pin becomes a load strobe for an external offset-register block. That block supplies the almost-empty threshold n and the almost-full threshold m, each normally 7. Each cycle, the write-side decoder classifies an access as IDLE, PUSH, LOAD or BLOCKED, and the read-side decoder does the same. An output-enable input turns the data bus into a high-impedance driver.

Top module: `xclk_fifo_pf`

## Requirements
- R1: While `rst_n` is low, and after its release until the first access, the block shows `empty_n`=0, `ae_n`=0, `full_n`=1 and `af_n`=1, and the output register holds zero.
- R2: The level of `wr_en2_ld` sampled on write-clock edges while `rst_n` is low selects the mode: 1 selects two-enable mode, 0 selects load mode. The mode stays fixed until the next reset, and in two-enable mode `ofs_wr_stb` never asserts.
- R3: In two-enable mode a word is stored on a rising `wr_clk` only when `wr_en1_n`=0, `wr_en2_ld`=1 and the FIFO is not full. Any other combination stores nothing.
- R4: In load mode, `wr_en1_n`=0 with `wr_en2_ld`=1 stores a word. `wr_en1_n`=0 with `wr_en2_ld`=0 asserts `ofs_wr_stb` and stores nothing. Both read enables low with `wr_en2_ld`=0 asserts `ofs_rd_stb`, and no word leaves the FIFO.
- R5: A read takes place on a rising `rd_clk` only when `rd_en1_n` and `rd_en2_n` are both 0 and the FIFO is not empty. The output register then takes the oldest unread word, so words leave in the order they entered.
- R6: A write while full and a read while empty are ignored. While empty, the output keeps the last word read.
- R7: With no traffic, `empty_n` is 0 exactly when no word is stored, and `full_n` is 0 exactly when DEPTH words are stored. Empty changes only on `rd_clk` edges, and full changes only on `wr_clk` edges.
- R8: With no traffic, `ae_n` is 0 when the stored count is at most `ae_offset` (n), and 1 when the count is n+1 or more.
- R9: With no traffic, `af_n` is 0 when the stored count is at least DEPTH minus `af_offset` (m), and 1 otherwise.
- R10: With `out_en_n`=1 the `rd_q` bus is high-impedance. With `out_en_n`=0 it carries the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock, unrelated to wr_clk |
| rst_n | input | 1 | Asynchronous reset, active low, shared by both domains |
| wr_data | input | DATA_W | Word to store |
| wr_en1_n | input | 1 | First write qualifier, active low |
| wr_en2_ld | input | 1 | Second write qualifier (active high) or load strobe (active low); its role is chosen at reset |
| rd_en1_n | input | 1 | First read qualifier, active low |
| rd_en2_n | input | 1 | Second read qualifier, active low |
| out_en_n | input | 1 | Output enable, active low; high floats rd_q |
| ae_offset | input | ADDR_W+1 | Almost-empty threshold n from the offset block |
| af_offset | input | ADDR_W+1 | Almost-full threshold m from the offset block |
| rd_q | output | DATA_W | Tri-state read data bus |
| empty_n | output | 1 | Low when empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| ae_n | output | 1 | Low when at most n words are stored (read domain) |
| af_n | output | 1 | Low when at least DEPTH-m words are stored (write domain) |
| ofs_wr_stb | output | 1 | Offset-register write access in load mode |
| ofs_rd_stb | output | 1 | Offset-register read access in load mode |

## Verification
On every clock, the assertions check the following: neither synchronized pointer difference goes above the depth or wraps below zero; a raised full flag freezes the write pointer; a raised empty flag freezes the output register; a load access moves neither pointer; the captured mode never changes after reset; and the write pointer never advances by more than one. Only the bench scenarios can show the rest. These are word ordering across two unrelated clocks, the exact flag levels at each count and each offset setting, the data held after reads on an empty FIFO, and the high-impedance bus.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

    // Role of the dual-purpose write pin, captured while reset is low
    typedef enum logic [0:0] {
        MODE_TWO_EN = 1'b0,
        MODE_LOAD   = 1'b1
    } wmode_e;

    // Per-cycle classification of an access on either side
    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_PUSH    = 2'd1,
        ACC_LOAD    = 2'd2,
        ACC_BLOCKED = 2'd3
    } acc_e;

endpackage

// File: rtl/fifo_pf_sync.sv
module fifo_pf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_pf_mem.sv
module fifo_pf_mem #(
    parameter int DW = 9,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] cells [ENTRIES];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_pf_wctl.sv
module fifo_pf_wctl
    import fifo_pf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [AW:0]   af_ofs,
    input  logic [AW:0]   rgray_sync,
    output wmode_e        mode,
    output logic          push,
    output logic          ofs_wr_stb,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          af_n
);
    localparam int            PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    wmode_e        mode_d;
    acc_e          acc;
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] rbin_sync;
    logic [PW-1:0] fill_nx;
    logic          full_r;
    logic          af_r;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Mode state: next-state logic (captured only while reset is held)
    always_comb begin
        mode_d = mode;
        if (!rst_n) begin
            mode_d = wen2_ld ? MODE_TWO_EN : MODE_LOAD;
        end
    end

    // Mode state register: sampled by write clock, no async clear on purpose
    always_ff @(posedge wr_clk) begin
        mode <= mode_d;
    end

    // Output decode of the mode state
    always_comb begin
        acc = ACC_IDLE;
        if (rst_n && !wen1_n) begin
            unique case (mode)
                MODE_TWO_EN: begin
                    if (wen2_ld) acc = full_r ? ACC_BLOCKED : ACC_PUSH;
                end
                MODE_LOAD: begin
                    if (!wen2_ld)    acc = ACC_LOAD;
                    else if (full_r) acc = ACC_BLOCKED;
                    else             acc = ACC_PUSH;
                end
            endcase
        end
    end

    assign push       = (acc == ACC_PUSH);
    assign ofs_wr_stb = (acc == ACC_LOAD);
    assign rbin_sync  = gray_to_bin(rgray_sync);
    assign wbin_nx    = wbin + {{AW{1'b0}}, push};
    assign fill_nx    = wbin_nx - rbin_sync;
    assign waddr      = wbin[AW-1:0];
    assign full_n     = !full_r;
    assign af_n       = !af_r;

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            full_r <= 1'b0;
            af_r   <= 1'b0;
        end else begin
            wbin   <= wbin_nx;
            wgray  <= wbin_nx ^ (wbin_nx >> 1);
            full_r <= (fill_nx == DEPTH_V);
            af_r   <= (fill_nx >= (DEPTH_V - af_ofs));
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wbin - rbin_sync) <= DEPTH_V); // R6
    AST_FULL_BLOCKS: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full_r |=> $stable(wbin)); // R6
    AST_STEP_ONE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wbin == $past(wbin)) || (wbin == $past(wbin) + {{AW{1'b0}}, 1'b1})); // R3
    AST_LOAD_NO_PUSH: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (mode == MODE_LOAD && !wen2_ld) |=> $stable(wbin)); // R4
    AST_MODE_FIXED: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode)); // R2
endmodule

// File: rtl/fifo_pf_rctl.sv
module fifo_pf_rctl
    import fifo_pf_pkg::*;
#(
    parameter int DW = 9,
    parameter int AW = 4
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic          wen2_ld,
    input  wmode_e        mode,
    input  logic [AW:0]   ae_ofs,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] q_r,
    output logic          empty_n,
    output logic          ae_n,
    output logic          ofs_rd_stb
);
    localparam int            PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    acc_e          racc;
    logic          pop;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] wbin_sync;
    logic [PW-1:0] fill_nx;
    logic          empty_r;
    logic          ae_r;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Read access decode against the quasi-static mode state
    always_comb begin
        racc = ACC_IDLE;
        if (rst_n && !ren1_n && !ren2_n) begin
            unique case (mode)
                MODE_TWO_EN: racc = empty_r ? ACC_BLOCKED : ACC_PUSH;
                MODE_LOAD: begin
                    if (!wen2_ld)     racc = ACC_LOAD;
                    else if (empty_r) racc = ACC_BLOCKED;
                    else              racc = ACC_PUSH;
                end
            endcase
        end
    end

    assign pop        = (racc == ACC_PUSH);
    assign ofs_rd_stb = (racc == ACC_LOAD);
    assign wbin_sync  = gray_to_bin(wgray_sync);
    assign rbin_nx    = rbin + {{AW{1'b0}}, pop};
    assign fill_nx    = wbin_sync - rbin_nx;
    assign raddr      = rbin[AW-1:0];
    assign empty_n    = !empty_r;
    assign ae_n       = !ae_r;

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            empty_r <= 1'b1;
            ae_r    <= 1'b1;
            q_r     <= '0;
        end else begin
            rbin    <= rbin_nx;
            rgray   <= rbin_nx ^ (rbin_nx >> 1);
            empty_r <= (fill_nx == '0);
            ae_r    <= (fill_nx <= ae_ofs);
            if (pop) begin
                q_r <= mem_rdata;
            end
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (wbin_sync - rbin) <= DEPTH_V); // R6
    AST_EMPTY_HOLDS_Q: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty_r |=> $stable(q_r)); // R6
    AST_LOAD_NO_POP: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (racc == ACC_LOAD) |=> $stable(rbin)); // R4
endmodule

// File: rtl/xclk_fifo_pf.sv
module xclk_fifo_pf
    import fifo_pf_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              out_en_n,
    input  logic [ADDR_W:0]   ae_offset,
    input  logic [ADDR_W:0]   af_offset,
    output wire  [DATA_W-1:0] rd_q,
    output logic              empty_n,
    output logic              full_n,
    output logic              ae_n,
    output logic              af_n,
    output logic              ofs_wr_stb,
    output logic              ofs_rd_stb
);
    localparam int PTR_W = ADDR_W + 1;

    wmode_e              mode;
    logic                push;
    logic [ADDR_W-1:0]   waddr;
    logic [ADDR_W-1:0]   raddr;
    logic [PTR_W-1:0]    wgray;
    logic [PTR_W-1:0]    rgray;
    logic [PTR_W-1:0]    wgray_rs;
    logic [PTR_W-1:0]    rgray_ws;
    logic [DATA_W-1:0]   mem_rdata;
    logic [DATA_W-1:0]   q_reg;

    fifo_pf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wr_clk (wr_clk),
        .we     (push),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_rdata)
    );

    fifo_pf_wctl #(.AW(ADDR_W)) u_wctl (
        .wr_clk     (wr_clk),
        .rst_n      (rst_n),
        .wen1_n     (wr_en1_n),
        .wen2_ld    (wr_en2_ld),
        .af_ofs     (af_offset),
        .rgray_sync (rgray_ws),
        .mode       (mode),
        .push       (push),
        .ofs_wr_stb (ofs_wr_stb),
        .waddr      (waddr),
        .wgray      (wgray),
        .full_n     (full_n),
        .af_n       (af_n)
    );

    fifo_pf_rctl #(.DW(DATA_W), .AW(ADDR_W)) u_rctl (
        .rd_clk     (rd_clk),
        .rst_n      (rst_n),
        .ren1_n     (rd_en1_n),
        .ren2_n     (rd_en2_n),
        .wen2_ld    (wr_en2_ld),
        .mode       (mode),
        .ae_ofs     (ae_offset),
        .wgray_sync (wgray_rs),
        .mem_rdata  (mem_rdata),
        .raddr      (raddr),
        .rgray      (rgray),
        .q_r        (q_reg),
        .empty_n    (empty_n),
        .ae_n       (ae_n),
        .ofs_rd_stb (ofs_rd_stb)
    );

    fifo_pf_sync #(.W(PTR_W)) u_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_rs)
    );

    fifo_pf_sync #(.W(PTR_W)) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_ws)
    );

    assign rd_q = out_en_n ? {DATA_W{1'bz}} : q_reg;
endmodule

// File: tb/sim_xclk_fifo_pf.sv
module sim_xclk_fifo_pf;
    localparam int DEPTH = 16;
    localparam int NV    = 11;
    // fields: push count, pop count, n, m, expected stored count
    localparam logic [39:0] VEC [NV] = '{
        {8'd3, 8'd0,  8'd7, 8'd7, 8'd3},
        {8'd5, 8'd0,  8'd7, 8'd7, 8'd8},
        {8'd1, 8'd0,  8'd7, 8'd7, 8'd9},
        {8'd7, 8'd0,  8'd7, 8'd7, 8'd16},
        {8'd2, 8'd0,  8'd7, 8'd7, 8'd16},
        {8'd0, 8'd4,  8'd7, 8'd7, 8'd12},
        {8'd0, 8'd14, 8'd7, 8'd7, 8'd0},
        {8'd3, 8'd0,  8'd2, 8'd3, 8'd3},
        {8'd10, 8'd0, 8'd2, 8'd3, 8'd13},
        {8'd0, 8'd11, 8'd2, 8'd3, 8'd2},
        {8'd0, 8'd3,  8'd2, 8'd3, 8'd0}
    };

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst_n;
    logic [8:0] wr_data;
    logic       wr_en1_n, wr_en2_ld, rd_en1_n, rd_en2_n, out_en_n;
    logic [4:0] ae_offset, af_offset;
    tri   [8:0] q_bus;
    logic       empty_n, full_n, ae_n, af_n, ofs_wr_stb, ofs_rd_stb;

    int         n_tests = 0;
    int         n_fail  = 0;
    logic [8:0] q_model [$];
    logic [8:0] last_q;
    logic [8:0] dv;
    bit         load_mode;
    bit         stb_w, stb_r;

    for (genvar gi = 0; gi < 9; gi++) begin : g_pull
        pullup pu (q_bus[gi]);
    end

    always #10 wr_clk = ~wr_clk;
    always #17 rd_clk = ~rd_clk;

    xclk_fifo_pf u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld), .rd_en1_n(rd_en1_n),
        .rd_en2_n(rd_en2_n), .out_en_n(out_en_n), .ae_offset(ae_offset),
        .af_offset(af_offset), .rd_q(q_bus), .empty_n(empty_n), .full_n(full_n),
        .ae_n(ae_n), .af_n(af_n), .ofs_wr_stb(ofs_wr_stb), .ofs_rd_stb(ofs_rd_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [8:0] d, input logic w1, input logic w2);
        bit acc;
        @(negedge wr_clk);
        wr_data = d; wr_en1_n = w1; wr_en2_ld = w2;
        acc = full_n && !w1 && w2;
        #1 stb_w = ofs_wr_stb;
        @(negedge wr_clk);
        wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
        if (acc) q_model.push_back(d);
    endtask

    task automatic rd_raw(input logic r1, input logic r2, input string tag);
        bit acc;
        logic [8:0] e;
        @(negedge rd_clk);
        rd_en1_n = r1; rd_en2_n = r2;
        acc = empty_n && !r1 && !r2 && !(load_mode && !wr_en2_ld);
        #1 stb_r = ofs_rd_stb;
        @(negedge rd_clk);
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        if (acc) begin
            e = q_model.pop_front();
            last_q = e;
            chk(q_bus == e, "R5", int'(q_bus), int'(e));
        end else begin
            chk(q_bus == last_q, tag, int'(q_bus), int'(last_q));
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
    endtask

    task automatic check_reset_state();
        chk(empty_n == 1'b0, "R1", int'(empty_n), 0);
        chk(ae_n == 1'b0,    "R1", int'(ae_n), 0);
        chk(full_n == 1'b1,  "R1", int'(full_n), 1);
        chk(af_n == 1'b1,    "R1", int'(af_n), 1);
        chk(q_bus == 9'h000, "R1", int'(q_bus), 0);
    endtask

    task automatic check_flags(input int n, input int m);
        int c;
        c = q_model.size();
        chk(empty_n == (c != 0),         "R7", int'(empty_n), int'(c != 0));
        chk(full_n == (c != DEPTH),      "R7", int'(full_n), int'(c != DEPTH));
        chk(ae_n == (c > n),             "R8", int'(ae_n), int'(c > n));
        chk(af_n == !(c >= DEPTH - m),   "R9", int'(af_n), int'(!(c >= DEPTH - m)));
    endtask

    initial begin
        #3_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_data = '0; wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
        rd_en1_n = 1'b1; rd_en2_n = 1'b1; out_en_n = 1'b0;
        ae_offset = 5'd7; af_offset = 5'd7;
        load_mode = 1'b0; last_q = '0; dv = 9'h0A0; stb_w = 1'b0; stb_r = 1'b0;
        repeat (10) @(negedge wr_clk);
        rst_n = 1'b1;
        @(negedge rd_clk);
        check_reset_state(); // R1

        // table-driven traffic in two-enable mode
        for (int v = 0; v < NV; v++) begin
            ae_offset = VEC[v][20:16];
            af_offset = VEC[v][12:8];
            for (int k = 0; k < int'(VEC[v][39:32]); k++) begin
                wr_raw(dv, 1'b0, 1'b1);
                dv = dv + 9'd1;
            end
            for (int k = 0; k < int'(VEC[v][31:24]); k++) begin
                rd_raw(1'b0, 1'b0, "R6");
            end
            settle();
            chk(q_model.size() == int'(VEC[v][7:0]), "R7", q_model.size(), int'(VEC[v][7:0]));
            check_flags(int'(VEC[v][23:16]), int'(VEC[v][15:8]));
        end

        // two-enable mode: qualifier combinations (R3, R2)
        wr_raw(9'h155, 1'b0, 1'b0);
        chk(stb_w == 1'b0, "R2", int'(stb_w), 0);
        settle();
        chk(empty_n == 1'b0, "R3", int'(empty_n), 0);
        wr_raw(9'h0AA, 1'b1, 1'b1);
        settle();
        chk(empty_n == 1'b0, "R3", int'(empty_n), 0);
        wr_raw(9'h0C3, 1'b0, 1'b1);
        settle();
        chk(empty_n == 1'b1, "R3", int'(empty_n), 1);
        rd_raw(1'b0, 1'b1, "R5");
        settle();
        chk(empty_n == 1'b1, "R5", int'(empty_n), 1);
        rd_raw(1'b0, 1'b0, "R5");

        // output enable (R10)
        out_en_n = 1'b1;
        #2 chk(q_bus == 9'h1FF, "R10", int'(q_bus), 9'h1FF);
        out_en_n = 1'b0;
        #2 chk(q_bus == 9'h0C3, "R10", int'(q_bus), 9'h0C3);

        // reset into load mode (R2, R4)
        @(negedge wr_clk);
        rst_n = 1'b0; wr_en2_ld = 1'b0;
        repeat (4) @(negedge wr_clk);
        rst_n = 1'b1; wr_en2_ld = 1'b1;
        q_model.delete(); last_q = '0; load_mode = 1'b1;
        @(negedge rd_clk);
        check_reset_state(); // R1
        wr_raw(9'h111, 1'b0, 1'b0);
        chk(stb_w == 1'b1, "R2", int'(stb_w), 1);
        settle();
        chk(empty_n == 1'b0, "R4", int'(empty_n), 0);
        wr_raw(9'h122, 1'b0, 1'b1);
        settle();
        chk(empty_n == 1'b1, "R4", int'(empty_n), 1);
        @(negedge wr_clk);
        wr_en2_ld = 1'b0;
        rd_raw(1'b0, 1'b0, "R4");
        chk(stb_r == 1'b1, "R4", int'(stb_r), 1);
        @(negedge wr_clk);
        wr_en2_ld = 1'b1;
        rd_raw(1'b0, 1'b0, "R5");
        settle();
        chk(empty_n == 1'b0, "R6", int'(empty_n), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule